// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block produces the six digital gate-control levels for a phase-shifted full-bridge converter whose secondary uses synchronous rectification. An oscillator tick marks the start of each half-period. Two primary legs are driven as complementary pairs, each with its own dead time counted in system clocks. The leading leg (A/B) toggles on every tick, so it switches at half the tick rate. The lagging leg (C/D) follows it after a phase offset. That offset comes either from a digital compare value or from a single-cycle early-terminate strobe, which stands in for a current-limit comparator.

The two rectifier controls (E and F) follow the lagging leg in a make-before-break manner. The incoming rectifier switches on together with the primary edge. The outgoing rectifier switches off a programmed delay later. That delay drops to zero while the light-load flag is set, and also for any edge caused by the early-terminate strobe. The compare value is capped against the measured half-period, so the lagging leg always switches before the next tick.

Top module: `psfb_gate_sequencer`

## Requirements
- R1: Each oscillator tick flips the leading-leg target. The first tick after enable selects A, and B stays low until the second tick. With dead count dly_ab, A rises dly_ab+2 clocks after the clock in which the tick was sampled.
- R2: When the A/B target changes, the outgoing output falls. Both stay low for exactly dly_ab+1 clocks, and then the incoming output rises. A and B are never high in the same clock.
- R3: The C/D pair follows the same rule with its own count dly_cd: both low for dly_cd+1 clocks, and never both high.
- R4: In a half-period where A is the target, D falls phase_cmp+1 clocks after B falls and C is the incoming side. In a half-period where B is the target, C falls phase_cmp+1 clocks after A falls.
- R5: The compare value is limited to L-1-floor(L/32), where L is the number of clocks between the two most recent ticks. The first half-period after enable has no limit.
- R6: An early_term strobe in a half-period, sampled j clocks after the tick and before the compare has matched, moves the C/D target immediately. The outgoing C/D output then falls j clocks after the outgoing A/B output. A strobe after the C/D switch in that half-period has no effect.
- R7: When D falls, E rises in the same clock and F falls dly_ef clocks later. When C falls, F rises in the same clock and E falls dly_ef clocks later.
- R8: While light_load is high, the rectifier hand-over delay of R7 is zero, so both rectifier outputs switch in the same clock.
- R9: A C/D switch caused by early_term uses a hand-over delay of zero. The next switch caused by the compare uses dly_ef again.
- R10: While enable is sampled low, all six outputs are low from the next clock, ticks have no effect, and the sequence restarts from R1 once enable returns.
- R11: While rst_n is low, all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low clears outputs and sequence state |
| osc_tick | input | 1 | One-clock pulse starting each half-period |
| phase_cmp | input | CNT_W | Lagging-leg offset in clocks after the tick |
| early_term | input | 1 | One-clock strobe ending the lagging phase early |
| light_load | input | 1 | Forces zero rectifier hand-over delay |
| dly_ab | input | DLY_W | Dead-time count, leading leg |
| dly_cd | input | DLY_W | Dead-time count, lagging leg |
| dly_ef | input | DLY_W | Rectifier hand-over delay count |
| out_a | output | 1 | Leading leg, high side |
| out_b | output | 1 | Leading leg, low side |
| out_c | output | 1 | Lagging leg, high side |
| out_d | output | 1 | Lagging leg, low side |
| out_e | output | 1 | Rectifier control paired with D |
| out_f | output | 1 | Rectifier control paired with C |

## Verification
A stuck toggle or a mis-loaded dead-time counter shows up within one half-period. The incoming output of a pair then rises at the wrong clock, or both outputs of a pair overlap at once. A wrong compare or limit value moves the falling edge of the lagging leg relative to the leading leg in the very next half-period. A stale current-limit flag changes the E/F hand-over spacing on the first compare-driven edge after the strobe. The checks therefore measure edge-to-edge distances in clocks, taken within a single half-period.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  // Offset actually used by the lagging leg: the requested compare, limited
  // to roughly 97 % of the last measured half-period once one is known.
  function automatic int unsigned shift_cap(input int unsigned cmp,
                                            input int unsigned len,
                                            input bit          len_ok);
    int unsigned lim;
    lim = len - 1 - (len >> 5);
    if (!len_ok || cmp <= lim) return cmp;
    return lim;
  endfunction

  // Rectifier hand-over delay after the override conditions.
  function automatic int unsigned rect_delay(input int unsigned prog,
                                             input bit          light,
                                             input bit          limited);
    if (light || limited) return 0;
    return prog;
  endfunction

endpackage

// File: rtl/psfb_phase_ctrl.sv
module psfb_phase_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             osc_tick,
  input  logic [CNT_W-1:0] phase_cmp,
  input  logic             early_term,
  output logic             leg_want,
  output logic             cd_want,
  output logic             cl_flag
);

  logic             started_q;
  logic             fired_q;
  logic             len_ok_q;
  logic [CNT_W-1:0] ph_cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] eff_cmp;
  logic             fire_cmp;
  logic             fire_early;

  assign eff_cmp = CNT_W'(psfb_pkg::shift_cap(32'(phase_cmp), 32'(len_q), len_ok_q));

  // Compare match wins over a strobe arriving in the same clock.
  assign fire_cmp   = started_q && !fired_q && !osc_tick && (ph_cnt_q == eff_cmp);
  assign fire_early = started_q && !fired_q && !osc_tick && early_term && !fire_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_want  <= 1'b0;
      cd_want   <= 1'b0;
      cl_flag   <= 1'b0;
      started_q <= 1'b0;
      fired_q   <= 1'b0;
      len_ok_q  <= 1'b0;
      ph_cnt_q  <= '0;
      len_q     <= '0;
    end else if (!enable) begin
      leg_want  <= 1'b0;
      cd_want   <= 1'b0;
      cl_flag   <= 1'b0;
      started_q <= 1'b0;
      fired_q   <= 1'b0;
      len_ok_q  <= 1'b0;
      ph_cnt_q  <= '0;
      len_q     <= '0;
    end else if (osc_tick) begin
      leg_want  <= ~leg_want;
      started_q <= 1'b1;
      fired_q   <= 1'b0;
      ph_cnt_q  <= '0;
      if (started_q) begin
        len_ok_q <= 1'b1;
        len_q    <= (ph_cnt_q == '1) ? ph_cnt_q : ph_cnt_q + CNT_W'(1);
      end
    end else begin
      if (ph_cnt_q != '1) ph_cnt_q <= ph_cnt_q + CNT_W'(1);
      if (fire_cmp || fire_early) begin
        fired_q <= 1'b1;
        cd_want <= leg_want;
        cl_flag <= fire_early;
      end
    end
  end

endmodule

// File: rtl/psfb_bbm_pair.sv
// Break-before-make complementary pair: outgoing side drops at once,
// incoming side rises after dly+1 clocks with both low.
module psfb_bbm_pair #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             want,
  input  logic [DLY_W-1:0] dly,
  output logic             hi_out,
  output logic             lo_out
);

  logic             side_q;
  logic             pend_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_out <= 1'b0;
      lo_out <= 1'b0;
    end else if (!run) begin
      side_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_out <= 1'b0;
      lo_out <= 1'b0;
    end else if (want != side_q) begin
      side_q <= want;
      pend_q <= 1'b1;
      cnt_q  <= dly;
      hi_out <= 1'b0;
      lo_out <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        pend_q <= 1'b0;
        hi_out <= side_q;
        lo_out <= ~side_q;
      end else begin
        cnt_q <= cnt_q - DLY_W'(1);
      end
    end
  end

endmodule

// File: rtl/psfb_mbb_pair.sv
// Make-before-break pair: incoming side rises at once, outgoing side
// drops dly clocks later (same clock when dly is zero).
module psfb_mbb_pair #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             want,
  input  logic [DLY_W-1:0] dly,
  output logic             hi_out,
  output logic             lo_out
);

  logic             side_q;
  logic             pend_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_out <= 1'b0;
      lo_out <= 1'b0;
    end else if (!run) begin
      side_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      hi_out <= 1'b0;
      lo_out <= 1'b0;
    end else if (want != side_q) begin
      side_q <= want;
      if (want) hi_out <= 1'b1;
      else      lo_out <= 1'b1;
      if (dly == '0) begin
        pend_q <= 1'b0;
        if (want) lo_out <= 1'b0;
        else      hi_out <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        cnt_q  <= dly - DLY_W'(1);
      end
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        pend_q <= 1'b0;
        if (side_q) lo_out <= 1'b0;
        else        hi_out <= 1'b0;
      end else begin
        cnt_q <= cnt_q - DLY_W'(1);
      end
    end
  end

endmodule

// File: rtl/psfb_gate_sequencer.sv
module psfb_gate_sequencer #(
  parameter int CNT_W = 12,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             osc_tick,
  input  logic [CNT_W-1:0] phase_cmp,
  input  logic             early_term,
  input  logic             light_load,
  input  logic [DLY_W-1:0] dly_ab,
  input  logic [DLY_W-1:0] dly_cd,
  input  logic [DLY_W-1:0] dly_ef,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_d,
  output logic             out_e,
  output logic             out_f
);

  localparam int NUM_LEGS = 2;

  logic             leg_want;
  logic             cd_want;
  logic             cl_flag;
  logic [DLY_W-1:0] td3_eff;

  logic [NUM_LEGS-1:0] leg_target;
  logic [NUM_LEGS-1:0] leg_hi;
  logic [NUM_LEGS-1:0] leg_lo;
  logic [DLY_W-1:0]    leg_dly [NUM_LEGS];

  psfb_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .osc_tick   (osc_tick),
    .phase_cmp  (phase_cmp),
    .early_term (early_term),
    .leg_want   (leg_want),
    .cd_want    (cd_want),
    .cl_flag    (cl_flag)
  );

  assign leg_target = {cd_want, leg_want};
  assign leg_dly[0] = dly_ab;
  assign leg_dly[1] = dly_cd;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_bbm_pair #(.DLY_W(DLY_W)) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (enable),
      .want   (leg_target[g]),
      .dly    (leg_dly[g]),
      .hi_out (leg_hi[g]),
      .lo_out (leg_lo[g])
    );
  end

  assign td3_eff = DLY_W'(psfb_pkg::rect_delay(32'(dly_ef), light_load, cl_flag));

  psfb_mbb_pair #(.DLY_W(DLY_W)) u_rect (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (enable),
    .want   (cd_want),
    .dly    (td3_eff),
    .hi_out (out_e),
    .lo_out (out_f)
  );

  assign out_a = leg_hi[0];
  assign out_b = leg_lo[0];
  assign out_c = leg_hi[1];
  assign out_d = leg_lo[1];

endmodule

// File: rtl/psfb_gate_sequencer_sva.sv
module psfb_gate_sequencer_sva (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic osc_tick,
  input logic leg_want,
  input logic out_a,
  input logic out_b,
  input logic out_c,
  input logic out_d,
  input logic out_e,
  input logic out_f
);

  assert_ab_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  assert_cd_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_c && out_d));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(out_a || out_b || out_c || out_d || out_e || out_f));

  assert_leg_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_want != $past(leg_want)) |-> ($past(osc_tick) || !$past(enable)));

  assert_e_on_d_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $fell(out_d)) |-> out_e);

  assert_f_on_c_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $fell(out_c)) |-> out_f);

endmodule

bind psfb_gate_sequencer psfb_gate_sequencer_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .osc_tick (osc_tick),
  .leg_want (leg_want),
  .out_a    (out_a),
  .out_b    (out_b),
  .out_c    (out_c),
  .out_d    (out_d),
  .out_e    (out_e),
  .out_f    (out_f)
);

// File: tb/psfb_gate_sequencer_bench.sv
`timescale 1ns/1ps
module psfb_gate_sequencer_bench;

  // half_len, cmp, d_ab, d_cd, d_ef, light, full_check
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{ 40,  10,  0,  0,  0, 0, 1},
    '{ 64,   5,  3,  7,  4, 0, 1},
    '{ 80,  20, 10,  2,  9, 0, 1},
    '{ 64,  12,  2,  3,  6, 1, 1},
    '{ 64,   0,  1,  1,  2, 0, 1},
    '{ 64, 200,  1,  1,  0, 0, 0},
    '{100,  10, 40, 20, 15, 0, 1}
  };
  localparam int IA = 0, IB = 1, IC = 2, ID = 3, IE = 4, IF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        osc_tick = 1'b0;
  logic        early_term = 1'b0;
  logic        light_load = 1'b0;
  logic [11:0] phase_cmp = '0;
  logic [7:0]  dly_ab = '0, dly_cd = '0, dly_ef = '0;
  logic        out_a, out_b, out_c, out_d, out_e, out_f;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  psfb_gate_sequencer u_psfb_gate_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_tick(osc_tick),
    .phase_cmp(phase_cmp), .early_term(early_term), .light_load(light_load),
    .dly_ab(dly_ab), .dly_cd(dly_cd), .dly_ef(dly_ef),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
    .out_e(out_e), .out_f(out_f)
  );

  always #2.5 clk = ~clk;

  wire [5:0] outs = {out_f, out_e, out_d, out_c, out_b, out_a};

  int cyc = 0;
  int tick_cyc = 0;
  int ab_both = 0;
  int cd_both = 0;
  int t_rise [6] = '{default: 0};
  int t_fall [6] = '{default: 0};
  logic [5:0] prev = '0;

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 6; i++) begin
      if (outs[i] && !prev[i]) t_rise[i] = cyc;
      if (!outs[i] && prev[i]) t_fall[i] = cyc;
    end
    prev = outs;
    if (osc_tick) tick_cyc = cyc;
    if (out_a && out_b) ab_both++;
    if (out_c && out_d) cd_both++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cap_of(input int len, input int cmp);
    int lim;
    lim = len - 1 - len / 32;
    return (cmp > lim) ? lim : cmp;
  endfunction

  task automatic run_half(input int len, input int early_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); #1;
      osc_tick   = (i == 0);
      early_term = (early_at > 0) && (i == early_at);
    end
  endtask

  task automatic restart();
    @(negedge clk); #1; enable = 1'b0;
    @(negedge clk); #1; enable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int eff, d3x;
    repeat (3) @(negedge clk); #1;
    chk("R11 outputs low in reset", int'(outs), 0);
    rst_n = 1'b1;

    // Table walk: five half-periods per entry, last one is an A half.
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); #1;
      enable     = 1'b0;
      phase_cmp  = 12'(VEC[v][1]);
      dly_ab     = 8'(VEC[v][2]);
      dly_cd     = 8'(VEC[v][3]);
      dly_ef     = 8'(VEC[v][4]);
      light_load = (VEC[v][5] != 0);
      @(negedge clk); #1; enable = 1'b1;
      for (int h = 0; h < 5; h++) run_half(VEC[v][0], 0);
      @(negedge clk); #1;
      eff = cap_of(VEC[v][0], VEC[v][1]);
      chk("R2 dead B->A", t_rise[IA] - t_fall[IB], VEC[v][2] + 1);
      chk("R2 dead A->B", t_rise[IB] - t_fall[IA], VEC[v][2] + 1);
      if (VEC[v][1] > eff) chk("R5 capped offset", t_fall[ID] - t_fall[IB], eff + 1);
      else                 chk("R4 phase offset", t_fall[ID] - t_fall[IB], eff + 1);
      if (VEC[v][6] != 0) begin
        d3x = (VEC[v][5] != 0) ? 0 : VEC[v][4];
        chk("R3 dead D->C", t_rise[IC] - t_fall[ID], VEC[v][3] + 1);
        chk("R7 E rises with D fall", t_rise[IE] - t_fall[ID], 0);
        if (VEC[v][5] != 0) chk("R8 light-load hand-over", t_fall[IF] - t_fall[ID], d3x);
        else                chk("R7 F hand-over delay", t_fall[IF] - t_fall[ID], d3x);
      end
    end
    light_load = 1'b0;

    // First A pulse after enable, nothing before the tick.
    @(negedge clk); #1;
    enable = 1'b0; phase_cmp = 12'd10; dly_ab = 8'd4; dly_cd = 8'd1; dly_ef = 8'd1;
    @(negedge clk); #1; enable = 1'b1;
    repeat (8) @(negedge clk); #1;
    chk("R10 idle until tick", int'(outs), 0);
    run_half(40, 0);
    @(negedge clk); #1;
    chk("R1 first A after tick", t_rise[IA] - tick_cyc, 6);
    chk("R1 B low in first half", int'(out_b), 0);

    // Early termination and restore.
    @(negedge clk); #1;
    enable = 1'b0; phase_cmp = 12'd40; dly_ab = 8'd2; dly_cd = 8'd3; dly_ef = 8'd6;
    @(negedge clk); #1; enable = 1'b1;
    for (int h = 0; h < 4; h++) run_half(64, 0);
    run_half(64, 15);
    @(negedge clk); #1;
    chk("R6 early strobe offset", t_fall[ID] - t_fall[IB], 15);
    chk("R9 zero hand-over after limit", t_fall[IF] - t_fall[ID], 0);
    chk("R7 E rises with D fall (limit)", t_rise[IE] - t_fall[ID], 0);
    run_half(64, 0);
    @(negedge clk); #1;
    chk("R4 B-half offset", t_fall[IC] - t_fall[IA], 41);
    chk("R7 F rises with C fall", t_rise[IF] - t_fall[IC], 0);
    chk("R9 programmed delay restored", t_fall[IE] - t_fall[IC], 6);
    run_half(64, 50);
    @(negedge clk); #1;
    chk("R6 late strobe ignored offset", t_fall[ID] - t_fall[IB], 41);
    chk("R6 late strobe keeps delay", t_fall[IF] - t_fall[ID], 6);
    chk("R6 C stays high", int'(out_c), 1);
    run_half(64, 0);
    @(negedge clk); #1;
    chk("R9 no collapse after ignored strobe", t_fall[IE] - t_fall[IC], 6);

    // Disable mid-run.
    @(negedge clk); #1; enable = 1'b0;
    @(negedge clk); #1;
    chk("R10 outputs cleared", int'(outs), 0);
    run_half(20, 0);
    @(negedge clk); #1;
    chk("R10 tick ignored while disabled", int'(outs), 0);
    chk("R2 no A/B overlap seen", ab_both, 0);
    chk("R3 no C/D overlap seen", cd_both, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule